// File: doc/BRIEF.md
# Push-Button Combination Lock

This block is an electronic lock operated by three mechanical push buttons: one that clears the entry, one that enters the digit zero, and one that enters the digit one. The lock opens, and drives its unlock output high, once the digits 0, 1, 0, 1, 1 have been entered in that order. The raw button lines are asynchronous to the clock, and each one may be held for any number of cycles. Each line therefore passes through a flop synchronizer. The two digit lines then pass through a rising-edge detector, so that one press becomes one digit event.

A Moore state machine records how much of the code has been matched so far. The unlock output depends only on that state. A wrong digit does not always return the machine to the start. The machine falls back to the longest run of recent digits that still begins the code, so overlapping attempts are recognised.

Top module: `keypad_seq_lock`

## Requirements
- R1: With `SYNC_STAGES` = 2 and the machine in the cleared state, pressing 0,1,0,1,1 makes `unlock` high. `unlock` is low in every state that has not matched all five digits.
- R2: A press counts as exactly one digit, however many cycles the button is held (tested from 1 to 4 cycles).
- R3: `unlock` rises on the third rising clock edge after the raw line of the final digit goes high, and not on the second. The path has two synchronizer flops followed by the state register.
- R4: After a wrong digit, the matched length becomes the longest suffix of the entered digits that is also a prefix of 01011. For example, "0" then 0 stays at "0", "01" then 1 goes to empty, and "0101" then 0 goes to "010".
- R5: When the lock is open, a 0 press leaves "0" matched and a 1 press leaves nothing matched. Both presses drive `unlock` low.
- R6: With no press, the matched state and `unlock` do not change.
- R7: A cycle in which both digit events occur together is ignored, and the matched state is kept.
- R8: While the synchronized clear line is high, the machine goes to the empty state. This overrides any digit event in the same cycle.
- R9: After a clear press, `unlock` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rawClear | input | 1 | Unsynchronized clear button, active high |
| rawZero | input | 1 | Unsynchronized digit-0 button, active high |
| rawOne | input | 1 | Unsynchronized digit-1 button, active high |
| unlock | output | 1 | High while the full code is matched |

## Verification
Two pairs of events can reach the state machine in the same cycle: a clear and a digit event, and the two digit events together. The bench provokes each case by raising the buttons of a pair on the same clock phase, so that both arrive through equal-length synchronizers in one cycle. It then judges the result by the digits pressed next. From "0101", a following 1 opens the lock only if the state was held, and from the open state, a clear combined with a 0 must leave no partial match behind. A sweep over every six-digit sequence compares `unlock` after each press with a suffix-matching model computed in the bench.

// File: rtl/lock_pkg.sv
package lock_pkg;

  // Matched-length states; the code value equals the number of digits matched.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_M1   = 3'd1,
    ST_M2   = 3'd2,
    ST_M3   = 3'd3,
    ST_M4   = 3'd4,
    ST_OPEN = 3'd5
  } lockState_t;

  // Strobes handed from the button front end to the sequence control.
  typedef struct packed {
    logic clearHit;  // synchronized clear level
    logic zeroHit;   // one-cycle event, digit 0 pressed
    logic oneHit;    // one-cycle event, digit 1 pressed
  } strobes_t;

  localparam int BTN_COUNT = 3;
  localparam int BTN_CLEAR = 0;
  localparam int BTN_ZERO  = 1;
  localparam int BTN_ONE   = 2;

endpackage

// File: rtl/lock_btn_front.sv
module lock_btn_front
  import lock_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rawClear,
  input  logic     rawZero,
  input  logic     rawOne,
  output strobes_t strobes
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [BTN_COUNT-1:0] rawVec;
  logic [BTN_COUNT-1:0] levelVec;
  logic [BTN_COUNT-1:0] pulseVec;

  assign rawVec[BTN_CLEAR] = rawClear;
  assign rawVec[BTN_ZERO]  = rawZero;
  assign rawVec[BTN_ONE]   = rawOne;

  for (genvar g = 0; g < BTN_COUNT; g++) begin : g_btn
    logic [LAST:0] chain;
    logic          prevLevel;

    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk) chain <= {chain[LAST-1:0], rawVec[g]};
    end else begin : g_single
      always_ff @(posedge clk) chain <= rawVec[g];
    end

    always_ff @(posedge clk) prevLevel <= chain[LAST];

    assign levelVec[g] = chain[LAST];
    assign pulseVec[g] = chain[LAST] & ~prevLevel;
  end

  // Clear acts as a level; the digits act as edges.
  assign strobes.clearHit = levelVec[BTN_CLEAR];
  assign strobes.zeroHit  = pulseVec[BTN_ZERO];
  assign strobes.oneHit   = pulseVec[BTN_ONE];

  logic unusedPulse;
  assign unusedPulse = pulseVec[BTN_CLEAR] ^ levelVec[BTN_ZERO] ^ levelVec[BTN_ONE];

endmodule

// File: rtl/lock_seq_ctrl.sv
module lock_seq_ctrl
  import lock_pkg::*;
(
  input  logic       clk,
  input  strobes_t   strobes,
  output lockState_t curState,
  output logic       unlock
);

  lockState_t nextState;
  logic       digitValid;
  logic       digitOne;

  assign digitValid = strobes.zeroHit ^ strobes.oneHit;
  assign digitOne   = strobes.oneHit;

  always_comb begin
    nextState = curState;
    if (strobes.clearHit) begin
      nextState = ST_IDLE;
    end else begin
      case (curState)
        ST_IDLE: if (digitValid) nextState = digitOne ? ST_IDLE : ST_M1;
        ST_M1:   if (digitValid) nextState = digitOne ? ST_M2   : ST_M1;
        ST_M2:   if (digitValid) nextState = digitOne ? ST_IDLE : ST_M3;
        ST_M3:   if (digitValid) nextState = digitOne ? ST_M4   : ST_M1;
        ST_M4:   if (digitValid) nextState = digitOne ? ST_OPEN : ST_M3;
        ST_OPEN: if (digitValid) nextState = digitOne ? ST_IDLE : ST_M1;
        default: nextState = ST_IDLE;  // codes 6 and 7 recover at once
      endcase
    end
  end

  always_ff @(posedge clk) curState <= nextState;

  assign unlock = (curState == ST_OPEN);

endmodule

// File: rtl/keypad_seq_lock.sv
module keypad_seq_lock
  import lock_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rawClear,
  input  logic rawZero,
  input  logic rawOne,
  output logic unlock
);

  strobes_t   strobes;
  lockState_t curState;

  lock_btn_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
    .clk      (clk),
    .rawClear (rawClear),
    .rawZero  (rawZero),
    .rawOne   (rawOne),
    .strobes  (strobes)
  );

  lock_seq_ctrl ctrl_i (
    .clk      (clk),
    .strobes  (strobes),
    .curState (curState),
    .unlock   (unlock)
  );

endmodule

// File: rtl/lock_checker.sv
module lock_checker
  import lock_pkg::*;
(
  input logic       clk,
  input logic       unlock,
  input strobes_t   strobes,
  input lockState_t curState
);

  // Properties are judged only once a clear has brought the state to a known value.
  logic armed = 1'b0;
  always_ff @(posedge clk) if (strobes.clearHit) armed <= 1'b1;

  logic noEvent;
  assign noEvent = !strobes.clearHit && !strobes.zeroHit && !strobes.oneHit;

  p_open_after_one_r1: assert property (@(posedge clk) disable iff (!armed)
    $rose(unlock) |-> $past(strobes.oneHit) && $past(curState) == ST_M4);

  p_zero_single_r2: assert property (@(posedge clk) disable iff (!armed)
    strobes.zeroHit |=> !strobes.zeroHit);

  p_one_single_r2: assert property (@(posedge clk) disable iff (!armed)
    strobes.oneHit |=> !strobes.oneHit);

  p_open_one_drops_r5: assert property (@(posedge clk) disable iff (!armed)
    (curState == ST_OPEN && strobes.oneHit && !strobes.zeroHit && !strobes.clearHit)
    |=> curState == ST_IDLE && !unlock);

  p_quiet_hold_r6: assert property (@(posedge clk) disable iff (!armed)
    noEvent |=> $stable(curState) && $stable(unlock));

  p_both_ignored_r7: assert property (@(posedge clk) disable iff (!armed)
    (strobes.zeroHit && strobes.oneHit && !strobes.clearHit) |=> $stable(curState));

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!armed)
    strobes.clearHit |=> curState == ST_IDLE);

  p_locked_after_clear_r9: assert property (@(posedge clk) disable iff (!armed)
    strobes.clearHit |=> !unlock);

  p_legal_code_r4: assert property (@(posedge clk) disable iff (!armed)
    $past(armed) |-> curState inside {ST_IDLE, ST_M1, ST_M2, ST_M3, ST_M4, ST_OPEN});

endmodule

bind keypad_seq_lock lock_checker chk_i (
  .clk      (clk),
  .unlock   (unlock),
  .strobes  (strobes),
  .curState (curState)
);

// File: tb/keypad_seq_lock_tb.sv
module keypad_seq_lock_tb_top;

  logic clk = 1'b0;
  logic rawClear = 1'b0;
  logic rawZero = 1'b0;
  logic rawOne = 1'b0;
  logic unlock;

  int checks = 0;
  int errors = 0;
  int model  = 0;  // matched length, 0..5
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 4 ns period

  keypad_seq_lock #(.SYNC_STAGES(2)) dut_i (
    .clk(clk), .rawClear(rawClear), .rawZero(rawZero), .rawOne(rawOne), .unlock(unlock)
  );

  function automatic int codeBit(int i);
    // code 0,1,0,1,1
    return (i == 1 || i == 3 || i == 4) ? 1 : 0;
  endfunction

  // Longest suffix of (matched prefix + digit) that is a prefix of the code.
  function automatic int advance(int k, int d);
    int seq [6];
    for (int i = 0; i < k; i++) seq[i] = codeBit(i);
    seq[k] = d;
    for (int len = ((k + 1) > 5 ? 5 : (k + 1)); len > 0; len--) begin
      bit ok = 1'b1;
      for (int i = 0; i < len; i++)
        if (seq[k + 1 - len + i] != codeBit(i)) ok = 1'b0;
      if (ok) return len;
    end
    return 0;
  endfunction

  task automatic check(input logic actual, input logic expected, input string req);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: unlock actual %0b expected %0b (t=%0t)", req, actual, expected, $time);
    end
  endtask

  task automatic press(input int d, input int hold, input string req);
    @(negedge clk);
    if (d == 1) rawOne = 1'b1; else rawZero = 1'b1;
    repeat (hold) @(negedge clk);
    rawOne = 1'b0; rawZero = 1'b0;
    repeat (6) @(negedge clk);
    model = advance(model, d);
    check(unlock, model == 5, req);
  endtask

  task automatic clearLock();
    @(negedge clk);
    rawClear = 1'b1;
    repeat (3) @(negedge clk);
    rawClear = 1'b0;
    repeat (5) @(negedge clk);
    model = 0;
  endtask

  task automatic enterCode();
    press(0, 2, "R1"); press(1, 2, "R1"); press(0, 2, "R1");
    press(1, 2, "R1"); press(1, 2, "R1");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(negedge clk);
    clearLock();
    check(unlock, 1'b0, "R9 reset state");

    // R1 plain entry
    enterCode();
    check(unlock, 1'b1, "R1 open after code");

    // R5 exits from open
    press(0, 1, "R5 zero from open");
    check(unlock, 1'b0, "R5");
    clearLock();
    enterCode();
    press(1, 3, "R5 one from open");

    // R4 specific fallbacks
    clearLock();
    press(0, 1, "R4"); press(0, 1, "R4 0 then 0");
    press(1, 1, "R4"); press(1, 1, "R4 01 then 1");
    press(0, 1, "R4"); press(1, 1, "R4"); press(0, 1, "R4");
    press(1, 1, "R4"); press(0, 1, "R4 0101 then 0");
    press(1, 1, "R4"); press(1, 1, "R4 recovered to open");

    // R6 idle hold while open
    repeat (40) @(negedge clk);
    check(unlock, model == 5, "R6 hold with no press");

    // R3 latency of final digit
    clearLock();
    press(0, 1, "R3"); press(1, 1, "R3"); press(0, 1, "R3"); press(1, 1, "R3");
    @(negedge clk) rawOne = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(unlock, 1'b0, "R3 not after two edges");
    @(negedge clk);
    check(unlock, 1'b1, "R3 open after three edges");
    repeat (8) @(negedge clk);
    rawOne = 1'b0;
    repeat (6) @(negedge clk);
    model = 5;
    check(unlock, 1'b1, "R2 long hold counts once");

    // R7 both digits together from "0101" and from open
    clearLock();
    press(0, 1, "R7"); press(1, 1, "R7"); press(0, 1, "R7"); press(1, 1, "R7");
    @(negedge clk); rawZero = 1'b1; rawOne = 1'b1;
    repeat (2) @(negedge clk); rawZero = 1'b0; rawOne = 1'b0;
    repeat (6) @(negedge clk);
    check(unlock, 1'b0, "R7 both pressed");
    press(1, 1, "R7 state kept through double press");
    @(negedge clk); rawZero = 1'b1; rawOne = 1'b1;
    repeat (2) @(negedge clk); rawZero = 1'b0; rawOne = 1'b0;
    repeat (6) @(negedge clk);
    check(unlock, 1'b1, "R7 open kept");

    // R8 clear overrides a digit in the same cycle
    @(negedge clk); rawClear = 1'b1; rawZero = 1'b1;
    repeat (3) @(negedge clk); rawClear = 1'b0; rawZero = 1'b0;
    repeat (6) @(negedge clk);
    model = 0;
    check(unlock, 1'b0, "R8 clear with zero");
    press(1, 1, "R8"); press(0, 1, "R8"); press(1, 1, "R8");
    press(1, 1, "R8 no stale 0 after clear");

    // R2/R4 sweep over all six-digit sequences, varying hold length
    for (int s = 0; s < 64; s++) begin
      clearLock();
      for (int b = 5; b >= 0; b--)
        press((s >> b) & 1, 1 + ((s + b) % 4), "R4 sweep");
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule